// File: doc/BRIEF.md
# Time-of-Day Timer Control Register Block

This block is the register slave that software uses to steer a time-of-day timer subsystem. It sits on a simple 32-bit valid/ready bus with word addressing. It holds the timer configuration and the software load values. It turns writes to trigger registers into single-cycle command pulses. It also keeps a sticky status bit for the one-pulse-per-second event and drives an interrupt line from it.

A snapshot command freezes several live timer values in one clock edge. These are the system timer, the seconds of the external time bus, and the transmit and receive timers of every enabled port. Software can then read all of them as one consistent set. Each captured value stays unchanged until the next snapshot command.

Top module: `tod_ctrl_regs`

## Requirements
- R1: After synchronous reset, every stored field and every captured snapshot is 0, no pulse is active, `irq` is low, and every mapped word reads 0.
- R2: Read-write words return what was written, with reserved bits reading 0. The words are: configuration (word 0, 4+NPORTS bits), interrupt enable (word 2, bit 0), software seconds low (word 4, 32 bits), software seconds high (word 5, 16 bits), software nanoseconds (word 6, 30 bits), correction low (word 8, 32 bits), correction high (word 9, 31 bits), offset seconds low (word 10), offset seconds high (word 11, 16 bits) and offset nanoseconds (word 12, 30 bits). In the configuration word, bit 0 is the system timer enable, bit 1 the external bus enable, bits [3:2] the overwrite mode and bit 4+p the enable of port p. The configuration and load values appear unchanged on the output ports.
- R3: A write with bit 0 set to word 1 makes `snap_pulse` high for exactly the following cycle. A write with bit 0 clear gives no pulse. Word 1 always reads 0.
- R4: In a write to word 7, bit 0 gives a one-cycle `load_tod_pulse` and bit 1 gives a one-cycle `load_ofs_pulse`. The two bits act independently, zero bits are ignored, and word 7 always reads 0.
- R5: A snapshot captures the live system time and the bus seconds at the edge that accepts the write. Each timer word packs seconds in bits [77:30] and nanoseconds in [29:0]. The system time reads as seconds low at word 0x40, seconds high at 0x41 and nanoseconds at 0x42. The bus seconds read as low at 0x48 and high at 0x49. The captured values hold while the live inputs move on.
- R6: Port p owns the 16-word window starting at word 0x80+16p. Its transmit snapshot reads at offsets 5 (nanoseconds), 6 (seconds low) and 7 (seconds high). Its receive snapshot reads at offsets 13, 14 and 15. A snapshot updates a port's values only while that port's enable bit is set. A disabled port keeps its previous values.
- R7: Writes to the snapshot read-only words leave their contents unchanged.
- R8: A high cycle on `pps_in` sets status bit 0 at word 3. The bit stays set until it is cleared.
- R9: A write to word 3 with bit 0 set clears the status bit. A write with bit 0 clear leaves it unchanged.
- R10: When a pulse on `pps_in` and a clearing write occur in the same cycle, the status bit ends up set.
- R11: `irq` is high exactly while status bit 0 and enable bit 0 are both set.
- R12: Unmapped words read 0, and writes to them change no register. This includes the other offsets of a port window and windows beyond NPORTS.
- R13: `req_ready` is always high. Every read request is answered with `rsp_valid` high in the next cycle, with the data in `rsp_rdata`. Writes produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request valid |
| req_ready | output | 1 | Bus request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read |
| rsp_rdata | output | 32 | Read data |
| pps_in | input | 1 | One-pulse-per-second event |
| sys_time_in | input | 78 | Live system time {sec, ns} |
| bus_sec_in | input | 48 | Live external bus seconds |
| tx_time_in | input | NPORTS*78 | Live per-port transmit times, port p at slice p |
| rx_time_in | input | NPORTS*78 | Live per-port receive times, port p at slice p |
| cfg_sys_en | output | 1 | System timer enable |
| cfg_bus_en | output | 1 | External time bus enable |
| cfg_ovr_mode | output | 2 | Overwrite mode |
| cfg_port_en | output | NPORTS | Per-port timer enables |
| sw_sec | output | 48 | Software seconds load value |
| sw_ns | output | 30 | Software nanoseconds load value |
| sw_cf | output | 63 | Software correction load value |
| ofs_sec | output | 48 | Signed system seconds offset |
| ofs_ns | output | 30 | Signed system nanoseconds offset |
| snap_pulse | output | 1 | Snapshot command pulse |
| load_tod_pulse | output | 1 | Load time-of-day command pulse |
| load_ofs_pulse | output | 1 | Load offset command pulse |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties check several relations on every cycle. Each command pulse must follow a matching bus write. A captured timer must equal the live value of the previous edge, and must stay stable when no capture is taken. The status bit must stay set, must be set after an event even when a clear arrives with it, and must drop after a clear without an event. Read responses must trail read requests by one cycle. Other behaviour is shown only by the bench scenarios against its reference model. These are the exact read values of each word and its reserved bits, and the per-port capture gating by the enable bits. They also include the silence of unmapped and read-only words, and the enable masking of the interrupt line.

// File: rtl/tod_regs_pkg.sv
package tod_regs_pkg;

    localparam int SEC_W  = 48;
    localparam int NS_W   = 30;
    localparam int TIME_W = SEC_W + NS_W;
    localparam int CFH_W  = 31;

    typedef struct packed {
        logic [SEC_W-1:0] sec;
        logic [NS_W-1:0]  ns;
    } tod_time_t;

    typedef enum logic [1:0] {
        OVR_NONE = 2'd0,
        OVR_BUS  = 2'd1,
        OVR_SW   = 2'd2,
        OVR_RSVD = 2'd3
    } ovr_mode_e;

    // word addresses of the global registers
    localparam logic [9:0] W_CFG   = 10'h000;
    localparam logic [9:0] W_SNAP  = 10'h001;
    localparam logic [9:0] W_IEN   = 10'h002;
    localparam logic [9:0] W_IST   = 10'h003;
    localparam logic [9:0] W_SWSL  = 10'h004;
    localparam logic [9:0] W_SWSH  = 10'h005;
    localparam logic [9:0] W_SWNS  = 10'h006;
    localparam logic [9:0] W_LOAD  = 10'h007;
    localparam logic [9:0] W_CFL   = 10'h008;
    localparam logic [9:0] W_CFH   = 10'h009;
    localparam logic [9:0] W_OSL   = 10'h00A;
    localparam logic [9:0] W_OSH   = 10'h00B;
    localparam logic [9:0] W_ONS   = 10'h00C;
    localparam logic [9:0] W_SYSSL = 10'h040;
    localparam logic [9:0] W_SYSSH = 10'h041;
    localparam logic [9:0] W_SYSNS = 10'h042;
    localparam logic [9:0] W_BUSL  = 10'h048;
    localparam logic [9:0] W_BUSH  = 10'h049;

    // per-port window: upper bits select the window, lower nibble the word
    localparam logic [5:0] PORT_WIN_BASE = 6'h08;
    localparam logic [3:0] PW_TX_NS = 4'h5;
    localparam logic [3:0] PW_TX_SL = 4'h6;
    localparam logic [3:0] PW_TX_SH = 4'h7;
    localparam logic [3:0] PW_RX_NS = 4'hD;
    localparam logic [3:0] PW_RX_SL = 4'hE;
    localparam logic [3:0] PW_RX_SH = 4'hF;

    function automatic logic [31:0] f_sec_lo(tod_time_t t);
        return t.sec[31:0];
    endfunction

    function automatic logic [31:0] f_sec_hi(tod_time_t t);
        return {16'b0, t.sec[47:32]};
    endfunction

    function automatic logic [31:0] f_ns(tod_time_t t);
        return {2'b0, t.ns};
    endfunction

endpackage

// File: rtl/tod_snap_reg.sv
module tod_snap_reg #(
    parameter int W = 78
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic [W-1:0] live,
    output logic [W-1:0] held
);

    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (cap)
            held <= live;
    end

    // R5
    capture_chk: assert property (@(posedge clk) disable iff (rst)
        cap |=> (held == $past(live)));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cap |=> $stable(held));

endmodule

// File: rtl/tod_irq_ctrl.sv
module tod_irq_ctrl #(
    parameter int NSRC = 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en_wr,
    input  logic [NSRC-1:0] en_wdata,
    input  logic            clr_wr,
    input  logic [NSRC-1:0] clr_mask,
    input  logic [NSRC-1:0] evt,
    output logic [NSRC-1:0] en_q,
    output logic [NSRC-1:0] st_q,
    output logic            irq
);

    logic [NSRC-1:0] clr_eff;

    assign clr_eff = clr_wr ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= '0;
            st_q <= '0;
        end else begin
            if (en_wr)
                en_q <= en_wdata;
            st_q <= (st_q & ~clr_eff) | evt;
        end
    end

    assign irq = |(st_q & en_q);

    // R8
    sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_wr |=> ((st_q & $past(st_q)) == $past(st_q)));

    // R10
    set_prio_chk: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((st_q & $past(evt)) == $past(evt)));

    // R9
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((st_q & $past(clr_mask & ~evt)) == '0));

endmodule

// File: rtl/tod_ctrl_regs.sv
module tod_ctrl_regs
    import tod_regs_pkg::*;
#(
    parameter int NPORTS = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_write,
    input  logic [9:0]               req_addr,
    input  logic [31:0]              req_wdata,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_rdata,
    input  logic                     pps_in,
    input  logic [TIME_W-1:0]        sys_time_in,
    input  logic [SEC_W-1:0]         bus_sec_in,
    input  logic [NPORTS*TIME_W-1:0] tx_time_in,
    input  logic [NPORTS*TIME_W-1:0] rx_time_in,
    output logic                     cfg_sys_en,
    output logic                     cfg_bus_en,
    output logic [1:0]               cfg_ovr_mode,
    output logic [NPORTS-1:0]        cfg_port_en,
    output logic [SEC_W-1:0]         sw_sec,
    output logic [NS_W-1:0]          sw_ns,
    output logic [32+CFH_W-1:0]      sw_cf,
    output logic [SEC_W-1:0]         ofs_sec,
    output logic [NS_W-1:0]          ofs_ns,
    output logic                     snap_pulse,
    output logic                     load_tod_pulse,
    output logic                     load_ofs_pulse,
    output logic                     irq
);

    localparam int CFG_W = 4 + NPORTS;

    logic [9:0]        widx;
    logic              wr_en;
    logic              rd_en;
    logic              snap_hit;
    logic [CFG_W-1:0]  cfg_q;
    logic [31:0]       swsl_q;
    logic [15:0]       swsh_q;
    logic [NS_W-1:0]   swns_q;
    logic [31:0]       cfl_q;
    logic [CFH_W-1:0]  cfh_q;
    logic [31:0]       osl_q;
    logic [15:0]       osh_q;
    logic [NS_W-1:0]   ons_q;
    logic              snap_q;
    logic              ltod_q;
    logic              lofs_q;
    logic [0:0]        ien_q;
    logic [0:0]        ist_q;
    logic [TIME_W-1:0] sys_snap;
    logic [SEC_W-1:0]  bus_snap;
    logic [TIME_W-1:0] tx_snap [NPORTS];
    logic [TIME_W-1:0] rx_snap [NPORTS];
    logic [31:0]       rd_word;
    ovr_mode_e         ovr_mode;

    assign req_ready = 1'b1;
    assign widx      = req_addr;
    assign wr_en     = req_valid & req_write;
    assign rd_en     = req_valid & ~req_write;
    assign snap_hit  = wr_en && (widx == W_SNAP) && req_wdata[0];

    // storage and trigger registers
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            swsl_q <= '0;
            swsh_q <= '0;
            swns_q <= '0;
            cfl_q  <= '0;
            cfh_q  <= '0;
            osl_q  <= '0;
            osh_q  <= '0;
            ons_q  <= '0;
            snap_q <= 1'b0;
            ltod_q <= 1'b0;
            lofs_q <= 1'b0;
        end else begin
            snap_q <= snap_hit;
            ltod_q <= wr_en && (widx == W_LOAD) && req_wdata[0];
            lofs_q <= wr_en && (widx == W_LOAD) && req_wdata[1];
            if (wr_en) begin
                case (widx)
                    W_CFG:  cfg_q  <= req_wdata[CFG_W-1:0];
                    W_SWSL: swsl_q <= req_wdata;
                    W_SWSH: swsh_q <= req_wdata[15:0];
                    W_SWNS: swns_q <= req_wdata[NS_W-1:0];
                    W_CFL:  cfl_q  <= req_wdata;
                    W_CFH:  cfh_q  <= req_wdata[CFH_W-1:0];
                    W_OSL:  osl_q  <= req_wdata;
                    W_OSH:  osh_q  <= req_wdata[15:0];
                    W_ONS:  ons_q  <= req_wdata[NS_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    tod_irq_ctrl #(.NSRC(1)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .en_wr    (wr_en && (widx == W_IEN)),
        .en_wdata (req_wdata[0:0]),
        .clr_wr   (wr_en && (widx == W_IST)),
        .clr_mask (req_wdata[0:0]),
        .evt      (pps_in),
        .en_q     (ien_q),
        .st_q     (ist_q),
        .irq      (irq)
    );

    tod_snap_reg #(.W(TIME_W)) u_sys_snap (
        .clk  (clk),
        .rst  (rst),
        .cap  (snap_hit),
        .live (sys_time_in),
        .held (sys_snap)
    );

    tod_snap_reg #(.W(SEC_W)) u_bus_snap (
        .clk  (clk),
        .rst  (rst),
        .cap  (snap_hit),
        .live (bus_sec_in),
        .held (bus_snap)
    );

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        tod_snap_reg #(.W(TIME_W)) u_tx (
            .clk  (clk),
            .rst  (rst),
            .cap  (snap_hit & cfg_q[4+p]),
            .live (tx_time_in[p*TIME_W +: TIME_W]),
            .held (tx_snap[p])
        );
        tod_snap_reg #(.W(TIME_W)) u_rx (
            .clk  (clk),
            .rst  (rst),
            .cap  (snap_hit & cfg_q[4+p]),
            .live (rx_time_in[p*TIME_W +: TIME_W]),
            .held (rx_snap[p])
        );
    end

    // read decode
    always_comb begin
        rd_word = '0;
        case (widx)
            W_CFG:   rd_word = 32'(cfg_q);
            W_IEN:   rd_word = 32'(ien_q);
            W_IST:   rd_word = 32'(ist_q);
            W_SWSL:  rd_word = swsl_q;
            W_SWSH:  rd_word = {16'b0, swsh_q};
            W_SWNS:  rd_word = {2'b0, swns_q};
            W_CFL:   rd_word = cfl_q;
            W_CFH:   rd_word = {1'b0, cfh_q};
            W_OSL:   rd_word = osl_q;
            W_OSH:   rd_word = {16'b0, osh_q};
            W_ONS:   rd_word = {2'b0, ons_q};
            W_SYSSL: rd_word = f_sec_lo(tod_time_t'(sys_snap));
            W_SYSSH: rd_word = f_sec_hi(tod_time_t'(sys_snap));
            W_SYSNS: rd_word = f_ns(tod_time_t'(sys_snap));
            W_BUSL:  rd_word = bus_snap[31:0];
            W_BUSH:  rd_word = {16'b0, bus_snap[47:32]};
            default: begin
                for (int p = 0; p < NPORTS; p++) begin
                    if (widx[9:4] == PORT_WIN_BASE + 6'(p)) begin
                        case (widx[3:0])
                            PW_TX_NS: rd_word = f_ns(tod_time_t'(tx_snap[p]));
                            PW_TX_SL: rd_word = f_sec_lo(tod_time_t'(tx_snap[p]));
                            PW_TX_SH: rd_word = f_sec_hi(tod_time_t'(tx_snap[p]));
                            PW_RX_NS: rd_word = f_ns(tod_time_t'(rx_snap[p]));
                            PW_RX_SL: rd_word = f_sec_lo(tod_time_t'(rx_snap[p]));
                            PW_RX_SH: rd_word = f_sec_hi(tod_time_t'(rx_snap[p]));
                            default: ;
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= rd_en;
            rsp_rdata <= rd_en ? rd_word : '0;
        end
    end

    assign ovr_mode       = ovr_mode_e'(cfg_q[3:2]);
    assign cfg_sys_en     = cfg_q[0];
    assign cfg_bus_en     = cfg_q[1];
    assign cfg_ovr_mode   = ovr_mode;
    assign cfg_port_en    = cfg_q[4 +: NPORTS];
    assign sw_sec         = {swsh_q, swsl_q};
    assign sw_ns          = swns_q;
    assign sw_cf          = {cfh_q, cfl_q};
    assign ofs_sec        = {osh_q, osl_q};
    assign ofs_ns         = ons_q;
    assign snap_pulse     = snap_q;
    assign load_tod_pulse = ltod_q;
    assign load_ofs_pulse = lofs_q;

    // R3
    snap_src_chk: assert property (@(posedge clk) disable iff (rst)
        snap_pulse |-> $past(req_valid && req_write && (req_addr == W_SNAP) && req_wdata[0]));

    // R4
    load_src_chk: assert property (@(posedge clk) disable iff (rst)
        (load_tod_pulse || load_ofs_pulse) |-> $past(req_valid && req_write && (req_addr == W_LOAD)));

    // R13
    rsp_order_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(req_valid && !req_write));

    // R13
    ready_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> req_ready);

endmodule

// File: tb/test_tod_ctrl_regs.sv
module test_tod_ctrl_regs;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 2;
    localparam int TW = 78;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [9:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic pps_in = 1'b0;
    logic [TW-1:0] sys_time_in = '0;
    logic [47:0] bus_sec_in = '0;
    logic [NP*TW-1:0] tx_time_in = '0;
    logic [NP*TW-1:0] rx_time_in = '0;
    logic cfg_sys_en, cfg_bus_en;
    logic [1:0] cfg_ovr_mode;
    logic [NP-1:0] cfg_port_en;
    logic [47:0] sw_sec, ofs_sec;
    logic [29:0] sw_ns, ofs_ns;
    logic [62:0] sw_cf;
    logic snap_pulse, load_tod_pulse, load_ofs_pulse, irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    tod_ctrl_regs #(.NPORTS(NP)) i_tod_ctrl_regs (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .pps_in(pps_in),
        .sys_time_in(sys_time_in), .bus_sec_in(bus_sec_in),
        .tx_time_in(tx_time_in), .rx_time_in(rx_time_in),
        .cfg_sys_en(cfg_sys_en), .cfg_bus_en(cfg_bus_en), .cfg_ovr_mode(cfg_ovr_mode),
        .cfg_port_en(cfg_port_en), .sw_sec(sw_sec), .sw_ns(sw_ns), .sw_cf(sw_cf),
        .ofs_sec(ofs_sec), .ofs_ns(ofs_ns), .snap_pulse(snap_pulse),
        .load_tod_pulse(load_tod_pulse), .load_ofs_pulse(load_ofs_pulse), .irq(irq)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;
    bit started = 0;
    string cur_tag = "R1";

    // reference model state
    logic [5:0]  m_cfg;
    logic        m_ien, m_ist;
    logic [31:0] m_swsl, m_cfl, m_osl;
    logic [15:0] m_swsh, m_osh;
    logic [29:0] m_swns, m_ons;
    logic [30:0] m_cfh;
    logic [TW-1:0] m_sys;
    logic [47:0] m_bus;
    logic [TW-1:0] m_tx [NP];
    logic [TW-1:0] m_rx [NP];
    logic m_snap, m_ltod, m_lofs, m_rv;
    logic [31:0] m_rd;

    function automatic logic [31:0] m_read(input logic [9:0] a);
        logic [TW-1:0] t;
        int p;
        case (a)
            10'h000: return {26'b0, m_cfg};
            10'h002: return {31'b0, m_ien};
            10'h003: return {31'b0, m_ist};
            10'h004: return m_swsl;
            10'h005: return {16'b0, m_swsh};
            10'h006: return {2'b0, m_swns};
            10'h008: return m_cfl;
            10'h009: return {1'b0, m_cfh};
            10'h00A: return m_osl;
            10'h00B: return {16'b0, m_osh};
            10'h00C: return {2'b0, m_ons};
            10'h040: return m_sys[61:30];
            10'h041: return {16'b0, m_sys[77:62]};
            10'h042: return {2'b0, m_sys[29:0]};
            10'h048: return m_bus[31:0];
            10'h049: return {16'b0, m_bus[47:32]};
            default: begin
                if (a >= 10'h080 && a < 10'h080 + 10'(16*NP)) begin
                    p = int'(a - 10'h080) / 16;
                    t = a[3] ? m_rx[p] : m_tx[p];
                    case (a[2:0])
                        3'd5: return {2'b0, t[29:0]};
                        3'd6: return t[61:30];
                        3'd7: return {16'b0, t[77:62]};
                        default: return 32'h0;
                    endcase
                end
                return 32'h0;
            end
        endcase
    endfunction

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_cfg = '0; m_ien = 0; m_ist = 0; m_swsl = '0; m_cfl = '0; m_osl = '0;
            m_swsh = '0; m_osh = '0; m_swns = '0; m_ons = '0; m_cfh = '0;
            m_sys = '0; m_bus = '0;
            for (int p = 0; p < NP; p++) begin m_tx[p] = '0; m_rx[p] = '0; end
            m_snap = 0; m_ltod = 0; m_lofs = 0; m_rv = 0; m_rd = '0;
        end else begin
            m_rv = req_valid && !req_write;
            m_rd = m_rv ? m_read(req_addr) : 32'h0;
            m_snap = req_valid && req_write && req_addr == 10'h001 && req_wdata[0];
            m_ltod = req_valid && req_write && req_addr == 10'h007 && req_wdata[0];
            m_lofs = req_valid && req_write && req_addr == 10'h007 && req_wdata[1];
            if (m_snap) begin
                m_sys = sys_time_in;
                m_bus = bus_sec_in;
                for (int p = 0; p < NP; p++)
                    if (m_cfg[4+p]) begin
                        m_tx[p] = tx_time_in[p*TW +: TW];
                        m_rx[p] = rx_time_in[p*TW +: TW];
                    end
            end
            if (req_valid && req_write && req_addr == 10'h003 && req_wdata[0]) m_ist = 0;
            if (pps_in) m_ist = 1;
            if (req_valid && req_write) begin
                case (req_addr)
                    10'h000: m_cfg = req_wdata[5:0];
                    10'h002: m_ien = req_wdata[0];
                    10'h004: m_swsl = req_wdata;
                    10'h005: m_swsh = req_wdata[15:0];
                    10'h006: m_swns = req_wdata[29:0];
                    10'h008: m_cfl = req_wdata;
                    10'h009: m_cfh = req_wdata[30:0];
                    10'h00A: m_osl = req_wdata;
                    10'h00B: m_osh = req_wdata[15:0];
                    10'h00C: m_ons = req_wdata[29:0];
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input string tag, input logic [127:0] got, input logic [127:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s at %0t got %h exp %h", tag, $time, got, exp);
        end
    endtask

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            check("R13 rsp_valid", 128'(rsp_valid), 128'(m_rv));
            check({cur_tag, " rsp_rdata"}, 128'(rsp_rdata), 128'(m_rd));
            check("R13 req_ready", 128'(req_ready), 128'(1'b1));
            check("R3 snap_pulse", 128'(snap_pulse), 128'(m_snap));
            check("R4 load pulses", 128'({load_tod_pulse, load_ofs_pulse}), 128'({m_ltod, m_lofs}));
            check("R11 irq", 128'(irq), 128'(m_ist & m_ien));
            check("R2 cfg outputs", 128'({cfg_sys_en, cfg_bus_en, cfg_ovr_mode, cfg_port_en}),
                  128'({m_cfg[0], m_cfg[1], m_cfg[3:2], m_cfg[5:4]}));
            check("R2 load values", {sw_sec, sw_ns, ofs_sec[47:0]},
                  {m_swsh, m_swsl, m_swns, m_osh, m_osl});
            check("R2 cf/ofs ns", 128'({sw_cf, ofs_ns}), 128'({m_cfh, m_cfl, m_ons}));
        end
    end

    // live timer stimulus, moving every cycle
    int cnt = 0;
    initial begin
        forever begin
            @(posedge clk); #2;
            cnt++;
            sys_time_in = {16'hA5A5 ^ 16'(cnt), 32'h1000_0000 + 32'(cnt), 30'(cnt * 7)};
            bus_sec_in  = {16'h3C3C + 16'(cnt), 32'hBEEF_0000 ^ 32'(cnt)};
            for (int p = 0; p < NP; p++) begin
                tx_time_in[p*TW +: TW] = {16'(p + 1), 32'(cnt * 3 + p), 30'(cnt * 11 + p)};
                rx_time_in[p*TW +: TW] = {16'(p + 9), 32'(cnt * 5 + p), 30'(cnt * 13 + p)};
            end
        end
    end

    task automatic do_wr(input logic [9:0] a, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(posedge clk); #2;
        req_valid = 0; req_write = 0;
    endtask

    task automatic do_rd(input logic [9:0] a);
        req_valid = 1; req_write = 0; req_addr = a; req_wdata = 32'hDEAD_BEEF;
        @(posedge clk); #2;
        req_valid = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic finish_run;
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R13 watchdog got timeout exp completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 0;
        // R1: reset values
        cur_tag = "R1";
        foreach (rd_list_r1[i]) do_rd(rd_list_r1[i]);
        // R2: read-write storage with reserved bits
        cur_tag = "R2";
        for (int w = 0; w <= 12; w++) begin
            do_wr(10'(w), 32'hFFFF_FFFF);
            do_rd(10'(w));
        end
        for (int w = 0; w <= 12; w++) begin
            do_wr(10'(w), 32'h5A5A_5A5A ^ (32'(w) << 8));
            do_rd(10'(w));
        end
        do_wr(10'h000, 32'h0000_0009);
        do_rd(10'h000);
        // R3: snapshot trigger
        cur_tag = "R3";
        do_wr(10'h001, 32'h0000_0000);
        idle(1);
        do_wr(10'h001, 32'hFFFF_FFFE);
        do_wr(10'h001, 32'h1);
        do_rd(10'h001);
        // R4: load triggers
        cur_tag = "R4";
        do_wr(10'h007, 32'h1);
        do_wr(10'h007, 32'h2);
        do_wr(10'h007, 32'h3);
        do_wr(10'h007, 32'h0);
        do_rd(10'h007);
        // R5 / R6: capture with port 0 enabled only
        cur_tag = "R5";
        do_wr(10'h000, 32'h0000_0011);
        do_wr(10'h001, 32'h1);
        idle(4);
        foreach (rd_list_snap[i]) do_rd(rd_list_snap[i]);
        cur_tag = "R6";
        for (int p = 0; p < NP; p++)
            foreach (port_offs[k]) do_rd(10'h080 + 10'(16 * p) + port_offs[k]);
        do_wr(10'h000, 32'h0000_0030);
        do_wr(10'h001, 32'h1);
        idle(3);
        for (int p = 0; p < NP; p++)
            foreach (port_offs[k]) do_rd(10'h080 + 10'(16 * p) + port_offs[k]);
        // R7: writes to read-only snapshot words
        cur_tag = "R7";
        foreach (rd_list_snap[i]) do_wr(rd_list_snap[i], 32'h1234_5678);
        do_wr(10'h085, 32'hFFFF_FFFF);
        do_wr(10'h09F, 32'hFFFF_FFFF);
        foreach (rd_list_snap[i]) do_rd(rd_list_snap[i]);
        do_rd(10'h085);
        do_rd(10'h09F);
        // R8 / R11: sticky status and interrupt masking
        cur_tag = "R8";
        do_wr(10'h002, 32'h0);
        pps_in = 1; idle(1); pps_in = 0;
        idle(3);
        do_rd(10'h003);
        cur_tag = "R11";
        do_wr(10'h002, 32'h1);
        idle(2);
        do_rd(10'h002);
        // R9: write-one-to-clear
        cur_tag = "R9";
        do_wr(10'h003, 32'hFFFF_FFFE);
        do_rd(10'h003);
        do_wr(10'h003, 32'h1);
        do_rd(10'h003);
        // R10: set wins over clear
        cur_tag = "R10";
        pps_in = 1;
        do_wr(10'h003, 32'h1);
        pps_in = 0;
        do_rd(10'h003);
        do_wr(10'h003, 32'h1);
        do_rd(10'h003);
        // R12: unmapped words
        cur_tag = "R12";
        foreach (rd_list_unm[i]) do_wr(rd_list_unm[i], 32'hFFFF_FFFF);
        foreach (rd_list_unm[i]) do_rd(rd_list_unm[i]);
        for (int w = 0; w <= 12; w++) do_rd(10'(w));
        // R13: back-to-back reads
        cur_tag = "R13";
        do_rd(10'h004); do_rd(10'h005); do_rd(10'h040);
        idle(2);
        // R1: reset clears everything again
        cur_tag = "R1";
        rst = 1; idle(2); rst = 0;
        foreach (rd_list_r1[i]) do_rd(rd_list_r1[i]);
        idle(2);
        finish_run();
    end

    logic [9:0] rd_list_r1 [12] = '{10'h000, 10'h002, 10'h003, 10'h004, 10'h009,
                                    10'h00C, 10'h040, 10'h042, 10'h049, 10'h085,
                                    10'h09E, 10'h001};
    logic [9:0] rd_list_snap [5] = '{10'h040, 10'h041, 10'h042, 10'h048, 10'h049};
    logic [9:0] port_offs [6] = '{10'h5, 10'h6, 10'h7, 10'hD, 10'hE, 10'hF};
    logic [9:0] rd_list_unm [8] = '{10'h00D, 10'h043, 10'h04A, 10'h080, 10'h08C,
                                    10'h0A5, 10'h0B6, 10'h3FF};

endmodule